// File: doc/BRIEF.md
# DMA Channel Address and Count Registers

This block keeps the start address and the transfer count of each channel of a four-channel DMA engine. Software reaches it through an 8-bit port interface. One byte-pointer flip-flop is shared by every channel register. It decides whether a byte access goes to the low half or the high half of a 16-bit register, and it flips after each byte access. A 16-bit write path loads a whole register in one access and leaves the pointer as it is.

When a register becomes complete (its high byte is written, or it gets a 16-bit write), the channel's working address is reloaded from its base address and its progress counter is cleared. The data path reports progress by strobing a per-channel input with the number of units moved so far. Reads return the live address (working address plus progress) or the remaining count (scaled base count minus progress). A build parameter selects byte-addressed or word-addressed operation. In word mode the port decode moves up one bit, addresses and counts are doubled, and readback values are halved before a byte is picked.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every base register, working address, progress counter and the byte pointer are zero, so every readback byte is 0 and each channel's length output equals one unit.
- R2: In byte mode port bits [2:1] pick the channel and bit 0 picks address (0) or count (1). In word mode the same fields sit at bits [3:2] and bit 1.
- R3: The single byte pointer flips on every read and on every byte write, whatever channel or register is addressed.
- R4: A byte write with the pointer at 0 replaces bits [7:0] of the selected register from io_wdata[7:0] and keeps bits [15:8]. With the pointer at 1 it replaces bits [15:8] and keeps bits [7:0].
- R5: A high-byte write or a 16-bit write to either register of a channel sets that channel's working address to its (possibly just updated) base address and clears its progress. A low-byte write changes neither.
- R6: A 16-bit write (io_wide=1) loads all of io_wdata into the selected register and leaves the byte pointer unchanged.
- R7: An address read yields working address plus progress. A count read yields scaled base count minus progress. Both wrap at the internal width.
- R8: A read returns bits [7:0] of the readback value when the pointer is 0 and bits [15:8] when it is 1.
- R9: In word mode the working address is the base address shifted left by one and the base count is shifted left by one. The readback value is shifted right by one before the byte is chosen.
- R10: chan_len for each channel is the scaled base count plus one unit, where the unit is 1 in byte mode and 2 in word mode.
- R11: A pulse on ff_clr or on mst_rst forces the byte pointer to 0 on the next edge. This overrides a coincident toggle.
- R12: A pulse on xfer_stb[i] loads xfer_cnt into channel i's progress counter. A reload of the same channel in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_port | input | 3 (4 in word mode) | Port offset carrying the channel and register select |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe (always byte wide) |
| io_wide | input | 1 | Qualifies io_wr as a 16-bit write |
| io_wdata | input | 16 | Write data; byte writes use [7:0] |
| io_rdata | output | 8 | Readback byte, valid while io_rd is high |
| ff_clr | input | 1 | Clears the byte pointer |
| mst_rst | input | 1 | Master-reset strobe; clears the byte pointer |
| xfer_stb | input | 4 | Per-channel progress update strobe |
| xfer_cnt | input | 16 (17 in word mode) | Progress value loaded on a strobe |
| chan_addr | output | 4 x 16 (4 x 17) | Working address of each channel, flattened |
| chan_len | output | 4 x 17 (4 x 18) | Transfer length of each channel, flattened |

## Verification
Two instances run side by side on the same stimulus, one in byte mode and one in word mode. Any scaling or decode slip therefore shows up as a mismatch between modes that use the same channel and register. Byte writes are interleaved across channels and mixed with reads, so a pointer kept per channel, or one that ignores reads, returns the wrong half. Progress updates before and after reloads separate the sum and difference readback from a plain base readback. Low-byte-only writes tell a reload on the high byte apart from a reload on any write.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int WORD_MODE = 0,
  parameter int NCH = 4,
  localparam int SH = (WORD_MODE != 0) ? 1 : 0,
  localparam int CB = $clog2(NCH),
  localparam int PW = CB + 1 + SH,
  localparam int AW = 16 + SH,
  localparam int LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     io_port,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              io_wide,
  input  logic [15:0]       io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              ff_clr,
  input  logic              mst_rst,
  input  logic [NCH-1:0]    xfer_stb,
  input  logic [AW-1:0]     xfer_cnt,
  output logic [NCH*AW-1:0] chan_addr,
  output logic [NCH*LW-1:0] chan_len
);

  logic [15:0]   base_a [NCH];
  logic [15:0]   base_c [NCH];
  logic [AW-1:0] cur    [NCH];
  logic [AW-1:0] done   [NCH];
  logic          ff;

  logic [CB-1:0] chan;
  logic          sel;
  assign chan = io_port[SH+1 +: CB];
  assign sel  = io_port[SH];

  logic [15:0] old_v, wr_val, nxt_a;
  logic        reload, tog;
  assign old_v  = sel ? base_c[chan] : base_a[chan];
  assign wr_val = io_wide ? io_wdata :
                  ff      ? {io_wdata[7:0], old_v[7:0]} : {old_v[15:8], io_wdata[7:0]};
  assign nxt_a  = (!sel) ? wr_val : base_a[chan];
  assign reload = io_wr && (io_wide || ff);
  assign tog    = io_rd || (io_wr && !io_wide);

  logic [AW-1:0] rv;
  logic [15:0]   rsh;
  assign rv       = sel ? ((AW'(base_c[chan]) << SH) - done[chan]) : (cur[chan] + done[chan]);
  assign rsh      = rv[SH +: 16];
  assign io_rdata = ff ? rsh[15:8] : rsh[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur[i]    <= '0;
        done[i]   <= '0;
      end
    end else begin
      if (ff_clr || mst_rst) ff <= 1'b0;
      else if (tog)          ff <= ~ff;
      for (int i = 0; i < NCH; i++) begin
        if (xfer_stb[i]) done[i] <= xfer_cnt;
        if (io_wr && chan == CB'(i)) begin
          if (sel) base_c[i] <= wr_val;
          else     base_a[i] <= wr_val;
          if (reload) begin
            cur[i]  <= AW'(nxt_a) << SH;
            done[i] <= '0;
          end
        end
      end
    end
  end

  logic [NCH*AW-1:0] done_flat;
  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign chan_addr[g*AW +: AW] = cur[g];
    assign chan_len[g*LW +: LW]  = (LW'(base_c[g]) << SH) + (LW'(1) << SH);
    assign done_flat[g*AW +: AW] = done[g];
  end

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CB  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic              io_rd,
  input logic              io_wide,
  input logic              ff_clr,
  input logic              mst_rst,
  input logic              ff,
  input logic [CB-1:0]     chan,
  input logic [NCH*AW-1:0] done_flat
);

  // R1
  reset_ptr_chk: assert property (@(posedge clk) !rst_n |=> !ff);

  // R3
  ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_rd || (io_wr && !io_wide)) && !ff_clr && !mst_rst) |=> ff != $past(ff));

  // R6
  wide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_wide && !io_rd && !ff_clr && !mst_rst) |=> $stable(ff));

  // R11
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_clr || mst_rst) |=> !ff);

  // R5
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_wide || ff)) |=> done_flat[$past(chan)*AW +: AW] == '0);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .AW(AW), .CB(CB)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_wide(io_wide),
  .ff_clr(ff_clr), .mst_rst(mst_rst), .ff(ff), .chan(chan), .done_flat(done_flat)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0;
  logic [2:0] port_b;
  logic [3:0] port_w;
  logic io_wr = 0, io_rd = 0, io_wide = 0, ff_clr = 0, mst_rst = 0;
  logic [15:0] io_wdata = 0;
  logic [3:0] xfer_stb = 0;
  logic [15:0] xc_b;
  logic [16:0] xc_w;
  logic [7:0] rd_b, rd_w;
  logic [63:0] addr_b;
  logic [67:0] addr_w;
  logic [67:0] len_b;
  logic [71:0] len_w;

  dma_chan_regs #(.WORD_MODE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_port(port_b), .io_wr(io_wr), .io_rd(io_rd),
    .io_wide(io_wide), .io_wdata(io_wdata), .io_rdata(rd_b), .ff_clr(ff_clr),
    .mst_rst(mst_rst), .xfer_stb(xfer_stb), .xfer_cnt(xc_b),
    .chan_addr(addr_b), .chan_len(len_b));

  dma_chan_regs #(.WORD_MODE(1)) u_dutw (
    .clk(clk), .rst_n(rst_n), .io_port(port_w), .io_wr(io_wr), .io_rd(io_rd),
    .io_wide(io_wide), .io_wdata(io_wdata), .io_rdata(rd_w), .ff_clr(ff_clr),
    .mst_rst(mst_rst), .xfer_stb(xfer_stb), .xfer_cnt(xc_w),
    .chan_addr(addr_w), .chan_len(len_w));

  int total = 0, bad = 0;
  int base_a[4], base_c[4], cur_a[4], done[4];
  int ff = 0;
  logic [15:0] expq[$];
  string tagq[$];

  function automatic int rb(int m, int ch, int s);
    int v;
    if (s) v = ((base_c[ch] << m) - done[ch]) & ((1 << (16+m)) - 1);
    else   v = ((cur_a[ch] << m) + done[ch]) & ((1 << (16+m)) - 1);
    v = v >> m;
    return ff ? ((v >> 8) & 255) : (v & 255);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_port(int ch, int s);
    port_b = 3'((ch << 1) | s);
    port_w = 4'((ch << 2) | (s << 1));
  endtask

  task automatic wr_byte(int ch, int s, int d);
    set_port(ch, s);
    io_wr = 1; io_wide = 0; io_wdata = 16'(d & 255);
    if (!ff) begin
      if (s) base_c[ch] = (base_c[ch] & 'hff00) | (d & 255);
      else   base_a[ch] = (base_a[ch] & 'hff00) | (d & 255);
    end else begin
      if (s) base_c[ch] = (base_c[ch] & 255) | ((d & 255) << 8);
      else   base_a[ch] = (base_a[ch] & 255) | ((d & 255) << 8);
      cur_a[ch] = base_a[ch]; done[ch] = 0;
    end
    ff = !ff;
    @(posedge clk); #1 io_wr = 0;
  endtask

  task automatic wr_wide(int ch, int s, int d);
    set_port(ch, s);
    io_wr = 1; io_wide = 1; io_wdata = 16'(d);
    if (s) base_c[ch] = d & 'hffff; else base_a[ch] = d & 'hffff;
    cur_a[ch] = base_a[ch]; done[ch] = 0;
    @(posedge clk); #1 io_wr = 0; io_wide = 0;
  endtask

  task automatic rd(int ch, int s, string tag);
    set_port(ch, s);
    io_rd = 1;
    expq.push_back({8'(rb(0, ch, s)), 8'(rb(1, ch, s))});
    tagq.push_back(tag);
    ff = !ff;
    @(posedge clk); #1 io_rd = 0;
  endtask

  task automatic xfer(int ch, int n);
    xfer_stb = 4'(1 << ch); xc_b = 16'(n); xc_w = 17'(n);
    done[ch] = n;
    @(posedge clk); #1 xfer_stb = 0;
  endtask

  task automatic pulse_clr(bit master);
    if (master) mst_rst = 1; else ff_clr = 1;
    ff = 0;
    @(posedge clk); #1 mst_rst = 0; ff_clr = 0;
  endtask

  task automatic chk_ch(int ch, string tag);
    @(negedge clk);
    check({tag, " addr byte"}, int'(addr_b[ch*16 +: 16]), cur_a[ch]);
    check({tag, " addr word R9"}, int'(addr_w[ch*17 +: 17]), cur_a[ch] << 1);
    check({tag, " len byte R10"}, int'(len_b[ch*17 +: 17]), base_c[ch] + 1);
    check({tag, " len word R10"}, int'(len_w[ch*18 +: 18]), (base_c[ch] << 1) + 2);
    @(posedge clk); #1;
  endtask

  always @(negedge clk) if (io_rd) begin
    logic [15:0] e;
    string t;
    if (expq.size() == 0) begin
      total++; bad++;
      $display("FAIL scoreboard empty actual=%0h expected=none", rd_b);
    end else begin
      e = expq.pop_front(); t = tagq.pop_front();
      check({t, " byte"}, int'(rd_b), int'(e[15:8]));
      check({t, " word R9"}, int'(rd_w), int'(e[7:0]));
    end
  end

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin base_a[i] = 0; base_c[i] = 0; cur_a[i] = 0; done[i] = 0; end
    port_b = 0; port_w = 0; xc_b = 0; xc_w = 0;
    repeat (3) @(posedge clk); #1 rst_n = 1;
    chk_ch(0, "R1 reset");
    rd(0, 0, "R1 addr lo"); rd(0, 0, "R1 addr hi"); rd(3, 1, "R1 count lo");
    pulse_clr(0);
    // R4 R5 byte sequencing
    wr_byte(1, 0, 'h34);
    chk_ch(1, "R5 low byte no reload");
    wr_byte(1, 0, 'h12);
    chk_ch(1, "R5 high byte reload");
    rd(1, 0, "R8 addr lo"); rd(1, 0, "R8 addr hi");
    // R6 wide write keeps pointer
    wr_byte(3, 1, 'h77);
    wr_wide(2, 1, 'h0100);
    rd(2, 1, "R6 pointer kept, count hi");
    // R12 R7 progress on count
    xfer(2, 'h10);
    rd(2, 1, "R12 R7 count lo"); rd(2, 1, "R7 count hi");
    wr_wide(2, 0, 'h4000);
    xfer(2, 5);
    rd(2, 0, "R7 addr lo"); rd(2, 0, "R7 addr hi");
    // R12 reload beats strobe on same channel
    xfer_stb = 4'b0100; xc_b = 16'h22; xc_w = 17'h22;
    wr_wide(2, 0, 'h4100);
    xfer_stb = 0;
    rd(2, 0, "R12 reload wins lo");
    // R3 shared pointer across channels
    pulse_clr(0);
    wr_byte(3, 0, 'h9a);
    rd(1, 0, "R3 shared ptr hi");
    rd(1, 0, "R3 shared ptr lo");
    // R11 clear strobes
    rd(1, 0, "R11 pre clr");
    pulse_clr(0);
    rd(1, 0, "R11 ff_clr lo");
    pulse_clr(1);
    rd(1, 0, "R11 mst_rst lo");
    // R11 clear overrides a coincident read toggle
    set_port(1, 0); io_rd = 1; ff_clr = 1;
    expq.push_back({8'(rb(0, 1, 0)), 8'(rb(1, 1, 0))}); tagq.push_back("R11 clr with read");
    ff = 0;
    @(posedge clk); #1 io_rd = 0; ff_clr = 0;
    rd(1, 0, "R11 after clr+read lo");
    // R2 channel/register decode
    for (int c = 0; c < 4; c++) begin
      wr_wide(c, 0, 'h1000 * (c + 1) + 3);
      wr_wide(c, 1, 'h0200 + c * 'h31);
    end
    pulse_clr(0);
    for (int c = 0; c < 4; c++) begin
      rd(c, 0, "R2 addr lo"); rd(c, 1, "R2 count hi");
      chk_ch(c, "R2 decode");
    end
    // R5 high byte of count reloads address and clears progress
    xfer(0, 7);
    pulse_clr(0);
    wr_byte(0, 0, 'h55);
    rd(0, 0, "R5 low byte keeps progress hi");
    wr_byte(0, 1, 'h01);
    wr_byte(0, 1, 'h03);
    chk_ch(0, "R5 count high reload");
    rd(0, 0, "R5 cleared progress lo");
    // R7 wrap: progress larger than count
    xfer(3, 'h400);
    pulse_clr(0);
    rd(3, 1, "R7 wrap lo"); rd(3, 1, "R7 wrap hi");
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule